// File: doc/BRIEF.md
# Caller ID Ring-Window Sequencer

This controller sits between a telephone line's ring detector, a caller ID receiver and the relay that puts a termination across the line. It watches two active-low inputs: one marks ringing and one marks a detected carrier. It drives two outputs: a power-down level for the receiver and an enable for the termination relay.

The start of each ring burst opens a power-up window of fixed length. A new burst that arrives while the window is open restarts it in full. The first ring burst also arms the relay. The first carrier that follows, inside the window, engages the relay, and the carrier's end releases it. After that the relay stays off until ringing occurs again, even if another carrier appears. Two short bursts before the data, as in distinctive ringing, therefore give the same relay behaviour as a single burst. The window length is a parameter counted in clock cycles, so slow real-time values and short test values use the same logic.

Top module: `cid_ring_seq`

## Requirements
- R1: While reset is held and after it is released with both inputs high, `pwdn_o` is 1, `relay_o` is 0 and the relay is disarmed.
- R2: A high-to-low change on `ring_n_i` opens the window. Count as edge one the first rising clock edge that samples the new low value. On the fourth such edge `pwdn_o` goes to 0.
- R3: `pwdn_o` stays 0 for exactly `WIN_CYCLES` clock cycles after a single ring start. A low-to-high change on `ring_n_i` has no effect on the window.
- R4: A new ring start while the window is open restarts the full `WIN_CYCLES` count, measured from the new start with the same latency as R2.
- R5: While armed and inside the window, a high-to-low change on `carrier_n_i` sets `relay_o` to 1 on the third rising edge, counting as edge one the edge that first samples it.
- R6: A low-to-high change on `carrier_n_i` clears `relay_o` on the third such edge and disarms the relay. A later carrier low does not engage the relay until a new ring start.
- R7: `relay_o` is 1 only while the window is open. When the window expires with the carrier still low, `relay_o` falls on the same edge on which `pwdn_o` rises.
- R8: A carrier that arrives with no prior ring start leaves the relay off. Several ring starts before the carrier arm the relay just as one does.
- R9: When a ring start and a carrier end are first sampled on the same edge, arming wins and the relay remains armed for the next carrier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ring_n_i | input | 1 | Ring detect, active low, asynchronous |
| carrier_n_i | input | 1 | Carrier detect, active low, asynchronous |
| pwdn_o | output | 1 | Receiver power-down, 1 outside the window |
| relay_o | output | 1 | Termination relay enable |

## Verification
The arming latch has a set source (ring start) and a clear source (carrier end), and these two can land in the same cycle. The bench provokes this by driving the ring input low and the carrier input high in the same clock period, so both edges are sampled on one clock edge. It then judges the result by whether a following carrier engages the relay. A second collision is window expiry while the carrier is present. Here the bench checks that the relay and the power-down output change on the same edge.

// File: rtl/cid_pkg.sv
package cid_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

  typedef struct packed {
    logic ring_start;
    logic carrier_end;
    logic carrier_on;
    logic window_on;
  } cid_evt_t;

endpackage

// File: rtl/cid_sync.sv
module cid_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= RESET_VAL;
    else     chain_q[0] <= async_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= RESET_VAL;
        else     chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/cid_edge.sv
module cid_edge
  import cid_pkg::*;
#(
  parameter edge_kind_e KIND      = EDGE_FALL,
  parameter logic       RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic pulse_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RESET_VAL;
    else     prev_q <= level_i;
  end

  generate
    if (KIND == EDGE_FALL) begin : g_fall
      assign pulse_o = prev_q & ~level_i;
    end else begin : g_rise
      assign pulse_o = ~prev_q & level_i;
    end
  endgenerate

endmodule

// File: rtl/cid_window_timer.sv
module cid_window_timer #(
  parameter int unsigned WIN_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic active_o
);

  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WIN_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (trig_i)       cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign active_o = (cnt_q != '0);

  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    trig_i |=> cnt_q == LOAD_VAL);

  assert_countdown_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !trig_i) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

endmodule

// File: rtl/cid_relay_ctl.sv
module cid_relay_ctl
  import cid_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  cid_evt_t evt_i,
  output logic     engage_o
);

  logic armed_q;

  // A ring start outranks a carrier end that arrives in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)                    armed_q <= 1'b0;
    else if (evt_i.ring_start)  armed_q <= 1'b1;
    else if (evt_i.carrier_end) armed_q <= 1'b0;
  end

  assign engage_o = armed_q & evt_i.carrier_on & evt_i.window_on;

  assert_arm_wins_R9: assert property (@(posedge clk) disable iff (rst)
    evt_i.ring_start |=> armed_q);

  assert_disarm_R6: assert property (@(posedge clk) disable iff (rst)
    (evt_i.carrier_end && !evt_i.ring_start) |=> !armed_q);

endmodule

// File: rtl/cid_ring_seq.sv
module cid_ring_seq
  import cid_pkg::*;
#(
  parameter int unsigned WIN_CYCLES  = 2_000_000_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ring_n_i,
  input  logic carrier_n_i,
  output logic pwdn_o,
  output logic relay_o
);

  logic ring_s, car_s;
  logic ring_fall, car_rise;
  logic win_active;
  logic engage;
  cid_evt_t evt;

  cid_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_ring (
    .clk(clk), .rst(rst), .async_i(ring_n_i), .sync_o(ring_s));

  cid_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_car (
    .clk(clk), .rst(rst), .async_i(carrier_n_i), .sync_o(car_s));

  cid_edge #(.KIND(EDGE_FALL), .RESET_VAL(1'b1)) u_edge_ring (
    .clk(clk), .rst(rst), .level_i(ring_s), .pulse_o(ring_fall));

  cid_edge #(.KIND(EDGE_RISE), .RESET_VAL(1'b1)) u_edge_car (
    .clk(clk), .rst(rst), .level_i(car_s), .pulse_o(car_rise));

  cid_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .trig_i(ring_fall), .active_o(win_active));

  assign evt.ring_start  = ring_fall;
  assign evt.carrier_end = car_rise;
  assign evt.carrier_on  = ~car_s;
  assign evt.window_on   = win_active;

  cid_relay_ctl u_relay (
    .clk(clk), .rst(rst), .evt_i(evt), .engage_o(engage));

  always_ff @(posedge clk) begin
    if (rst) begin
      pwdn_o  <= 1'b1;
      relay_o <= 1'b0;
    end else begin
      pwdn_o  <= ~win_active;
      relay_o <= engage;
    end
  end

  assert_relay_in_window_R7: assert property (@(posedge clk) disable iff (rst)
    relay_o |-> !pwdn_o);

  assert_engage_needs_carrier_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(relay_o) |-> $past(~car_s));

  assert_ring_powers_up_R2: assert property (@(posedge clk) disable iff (rst)
    ring_fall |-> ##2 !pwdn_o);

endmodule

// File: tb/cid_ring_seq_tb_top.sv
`timescale 1ns/1ps
module cid_ring_seq_tb_top;

  localparam int WIN = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ring_n = 1'b1;
  logic car_n = 1'b1;
  logic pwdn, relay;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  cid_ring_seq #(.WIN_CYCLES(WIN), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .ring_n_i(ring_n), .carrier_n_i(car_n),
    .pwdn_o(pwdn), .relay_o(relay));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    logic  pw;
    logic  rl;
    string tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_bad = 0;

  task automatic expect_at(int at, logic pw, logic rl, string tag);
    exp_t e;
    int i;
    e.at = at; e.pw = pw; e.rl = rl; e.tag = tag;
    i = 0;
    while (i < sb.size() && sb[i].at <= at) i++;
    sb.insert(i, e);
  endtask

  task automatic go(int n);
    while (cyc < n) @(negedge clk);
  endtask

  always @(negedge clk) begin : monitor
    exp_t e;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      e = sb.pop_front();
      n_chk++;
      if (e.at < cyc) begin
        n_bad++;
        $display("FAIL %s: item for cycle %0d missed, actual cycle %0d expected %0d",
                 e.tag, e.at, cyc, e.at);
      end else if (pwdn !== e.pw || relay !== e.rl) begin
        n_bad++;
        $display("FAIL %s at cycle %0d: actual pwdn=%b relay=%b expected pwdn=%b relay=%b",
                 e.tag, cyc, pwdn, relay, e.pw, e.rl);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    int c;
    expect_at(2, 1'b1, 1'b0, "R1");
    go(4); rst = 1'b0;
    expect_at(6, 1'b1, 1'b0, "R1");

    // R8: carrier with no ring start before it
    c = 10; go(c); car_n = 1'b0;
    expect_at(c+3, 1'b1, 1'b0, "R8");
    expect_at(c+8, 1'b1, 1'b0, "R8");
    go(c+10); car_n = 1'b1;

    // R2 / R3: single ring start, window length, rise ignored
    c = 30; go(c); ring_n = 1'b0;
    expect_at(c+3,  1'b1, 1'b0, "R2");
    expect_at(c+4,  1'b0, 1'b0, "R2");
    go(c+5); ring_n = 1'b1;
    expect_at(c+23, 1'b0, 1'b0, "R3");
    expect_at(c+24, 1'b1, 1'b0, "R3");

    // R4: retrigger restarts the full window
    c = 70; go(c); ring_n = 1'b0;
    go(c+3); ring_n = 1'b1;
    go(c+10); ring_n = 1'b0;
    go(c+13); ring_n = 1'b1;
    expect_at(c+24, 1'b0, 1'b0, "R4");
    expect_at(c+33, 1'b0, 1'b0, "R4");
    expect_at(c+34, 1'b1, 1'b0, "R4");

    // R5 / R6: engage, release, no re-engage
    c = 120; go(c); ring_n = 1'b0;
    go(c+3); ring_n = 1'b1;
    go(c+6); car_n = 1'b0;
    expect_at(c+8,  1'b0, 1'b0, "R5");
    expect_at(c+9,  1'b0, 1'b1, "R5");
    go(c+12); car_n = 1'b1;
    expect_at(c+14, 1'b0, 1'b1, "R6");
    expect_at(c+15, 1'b0, 1'b0, "R6");
    go(c+17); car_n = 1'b0;
    expect_at(c+20, 1'b0, 1'b0, "R6");
    expect_at(c+22, 1'b0, 1'b0, "R6");
    go(c+22); car_n = 1'b1;

    // R7: window expires with carrier still present
    c = 160; go(c); ring_n = 1'b0;
    go(c+3); ring_n = 1'b1;
    go(c+5); car_n = 1'b0;
    expect_at(c+23, 1'b0, 1'b1, "R7");
    expect_at(c+24, 1'b1, 1'b0, "R7");
    go(c+30); car_n = 1'b1;

    // R8: two quick bursts, then carrier
    c = 200; go(c); ring_n = 1'b0;
    go(c+4);  ring_n = 1'b1;
    go(c+8);  ring_n = 1'b0;
    go(c+12); ring_n = 1'b1;
    go(c+16); car_n = 1'b0;
    expect_at(c+18, 1'b0, 1'b0, "R8");
    expect_at(c+19, 1'b0, 1'b1, "R8");
    go(c+20); car_n = 1'b1;
    expect_at(c+22, 1'b0, 1'b1, "R8");
    expect_at(c+23, 1'b0, 1'b0, "R8");

    // R9: ring start and carrier end sampled on the same edge
    c = 260; go(c); car_n = 1'b0;
    expect_at(c+4, 1'b1, 1'b0, "R9");
    go(c+6); ring_n = 1'b0; car_n = 1'b1;
    expect_at(c+10, 1'b0, 1'b0, "R9");
    go(c+9); ring_n = 1'b1;
    go(c+12); car_n = 1'b0;
    expect_at(c+14, 1'b0, 1'b0, "R9");
    expect_at(c+15, 1'b0, 1'b1, "R9");
    go(c+16); car_n = 1'b1;

    go(c+60);
    while (sb.size() > 0) begin
      n_chk++; n_bad++;
      $display("FAIL %s: actual unchecked expected check at cycle %0d",
               sb[0].tag, sb[0].at);
      void'(sb.pop_front());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule